// File: doc/BRIEF.md
# CRC-Protected SPI Sensor Frame Engine

This block runs one register access against a sensor over an SPI link in which every access takes two 32-bit frames. A client presents a 5-bit register address, a read/write flag and a 16-bit write value, then pulses `start`. The engine builds a command word and appends an inverted CRC-8. It shifts the word out in SPI mode 0 with chip select held low. It then raises chip select for a timed idle gap and runs a second 32-bit frame to collect the sensor's reply.

On the reply the engine checks the trailing CRC byte against the first three bytes. It extracts the two return-status bits and sign-extends the 16-bit big-endian payload. After a second idle gap it pulses `done` together with the data word and two error flags. The SCLK divider and the gap timer both sit inside the block. The gap length follows from the nominal system clock frequency and a gap time in microseconds.

Top module: `spi_frame_engine`

## Requirements
- R1: Byte 0 of the command frame (frame bits 31:24) is laid out as follows: bit 7 is 1 for a write and 0 for a read, bits 6:2 hold the address, and bits 1:0 are 0.
- R2: Frame bits 23:8 carry the 16-bit write value, high byte first. On a read these bits are 0.
- R3: Frame bits 7:0 hold the bitwise inverse of a CRC-8 with polynomial 0x1D. The CRC register starts at 0xFF and consumes frame bits 31 down to 8, most significant bit first.
- R4: Each frame is shifted most significant bit first in SPI mode 0. SCLK is low whenever chip select is high. MOSI changes only while SCLK is low, and each frame has exactly 32 SCLK rising edges with chip select low. Every access produces exactly two frames.
- R5: Between the command frame and the reply frame, chip select stays high for at least GAP_CYC = (CLK_HZ/1e6)*GAP_US clock cycles. The same minimum gap follows the reply frame before `done`.
- R6: `rdata` is the sign-extended value of reply bits 23:8, where bit 31 is the first bit received.
- R7: `crc_err` is 1 exactly when reply bits 7:0 differ from the inverted CRC of reply bits 31:8, computed by the rule in R3.
- R8: `status_err` is 1 exactly when reply bits 25:24 (the low two bits of byte 0) equal 3.
- R9: `done` is a one-cycle pulse. `busy` is 1 from the cycle after an accepted `start` until `done`. A `start` raised while busy is ignored and produces no extra frame.
- R10: After reset, chip select is high, SCLK is low, and `busy`, `done`, `crc_err` and `status_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an access (sampled when idle) |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write value |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Sign-extended reply payload |
| crc_err | output | 1 | Reply CRC mismatch |
| status_err | output | 1 | Reply status field equals 3 |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the sensor |
| miso | input | 1 | Serial data from the sensor |

## Verification
The sweep covers every address in both read and write direction. Each write carries a distinct data pattern, so a swapped byte, a misplaced flag or a wrong CRC seed shows up as a difference in the captured command frame. On the reply side, payloads at the signed extremes (0x7FFF, 0x8000, 0xFFFF, 0x0000) separate correct sign extension from zero extension. All four status values show that only the value 3 raises the error. Replies with a flipped CRC bit, interleaved with intact ones, show that the mismatch flag tracks the reply and not earlier history. A spurious `start` raised in the middle of an access confirms that it neither alters the frame nor adds one.

// File: rtl/spife_pkg.sv
package spife_pkg;
    localparam int          FRAME_W  = 32;
    localparam int          HDR_W    = 24;
    localparam int          ADDR_W   = 5;
    localparam logic [7:0]  CRC_POLY = 8'h1D;
    localparam logic [7:0]  CRC_SEED = 8'hFF;
    localparam logic [1:0]  RS_FAULT = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_GAP_A,
        ST_RSP,
        ST_GAP_B
    } eng_state_e;
endpackage

// File: rtl/spife_crc8.sv
module spife_crc8 #(
    parameter int         DATA_W = 24,
    parameter logic [7:0] POLY   = 8'h1D,
    parameter logic [7:0] SEED   = 8'hFF
) (
    input  logic [DATA_W-1:0] data,
    output logic [7:0]        crc_inv
);
    logic [7:0] acc;

    always_comb begin
        acc = SEED;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (acc[7] ^ data[i]) acc = {acc[6:0], 1'b0} ^ POLY;
            else                  acc = {acc[6:0], 1'b0};
        end
        crc_inv = ~acc;
    end
endmodule

// File: rtl/spife_clkdiv.sv
module spife_clkdiv #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int            CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = (!en || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
    parameter int CLK_HZ     = 250_000_000,
    parameter int GAP_US     = 10,
    parameter int SCLK_HALF  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        wr_en,
    input  logic [4:0]  addr,
    input  logic [15:0] wdata,
    output logic        busy,
    output logic        done,
    output logic [31:0] rdata,
    output logic        crc_err,
    output logic        status_err,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);
    import spife_pkg::*;

    localparam int GAP_CYC = (CLK_HZ / 1_000_000) * GAP_US;
    localparam int GAP_W   = $clog2(GAP_CYC + 1);
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

    typedef struct packed {
        eng_state_e         st;
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx;
        logic [BIT_W-1:0]   bits;
        logic               ph;
        logic               sclk;
        logic               cs_n;
        logic [GAP_W-1:0]   gap;
        logic               done;
        logic [31:0]        rdata;
        logic               crc_err;
        logic               stat_err;
    } regs_t;

    regs_t r_d, r_q;

    logic [HDR_W-1:0] cmd_hdr;
    logic [7:0]       tx_crc;
    logic [7:0]       rx_crc;
    logic             tick;
    logic             shifting;

    assign cmd_hdr  = {wr_en, addr, 2'b00, (wr_en ? wdata : 16'h0000)};
    assign shifting = (r_q.st == ST_CMD) || (r_q.st == ST_RSP);

    spife_crc8 #(.DATA_W(HDR_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_tx_crc (
        .data    (cmd_hdr),
        .crc_inv (tx_crc)
    );

    spife_crc8 #(.DATA_W(HDR_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_rx_crc (
        .data    (r_q.rx[FRAME_W-1:8]),
        .crc_inv (rx_crc)
    );

    spife_clkdiv #(.HALF(SCLK_HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (shifting),
        .tick  (tick)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.tx   = {cmd_hdr, tx_crc};
                    r_d.st   = ST_CMD;
                    r_d.cs_n = 1'b0;
                    r_d.bits = '0;
                    r_d.ph   = 1'b0;
                    r_d.sclk = 1'b0;
                end
            end
            ST_CMD, ST_RSP: begin
                if (tick) begin
                    if (!r_q.ph) begin
                        r_d.sclk = 1'b1;
                        r_d.ph   = 1'b1;
                        if (r_q.st == ST_RSP) r_d.rx = {r_q.rx[FRAME_W-2:0], miso};
                    end else begin
                        r_d.sclk = 1'b0;
                        r_d.ph   = 1'b0;
                        r_d.tx   = {r_q.tx[FRAME_W-2:0], 1'b0};
                        if (r_q.bits == BIT_LAST) begin
                            r_d.cs_n = 1'b1;
                            r_d.gap  = '0;
                            r_d.st   = (r_q.st == ST_CMD) ? ST_GAP_A : ST_GAP_B;
                        end else begin
                            r_d.bits = r_q.bits + 1'b1;
                        end
                    end
                end
            end
            ST_GAP_A: begin
                if (r_q.gap == GAP_LAST) begin
                    r_d.st   = ST_RSP;
                    r_d.cs_n = 1'b0;
                    r_d.bits = '0;
                    r_d.ph   = 1'b0;
                    r_d.tx   = '0;
                end else begin
                    r_d.gap = r_q.gap + 1'b1;
                end
            end
            ST_GAP_B: begin
                if (r_q.gap == GAP_LAST) begin
                    r_d.st       = ST_IDLE;
                    r_d.done     = 1'b1;
                    r_d.rdata    = {{16{r_q.rx[23]}}, r_q.rx[23:8]};
                    r_d.crc_err  = (r_q.rx[7:0] != rx_crc);
                    r_d.stat_err = (r_q.rx[25:24] == RS_FAULT);
                end else begin
                    r_d.gap = r_q.gap + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.cs_n     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign done       = r_q.done;
    assign rdata      = r_q.rdata;
    assign crc_err    = r_q.crc_err;
    assign status_err = r_q.stat_err;
    assign sclk       = r_q.sclk;
    assign cs_n       = r_q.cs_n;
    assign mosi       = r_q.tx[FRAME_W-1];
endmodule

// File: rtl/spife_checker.sv
module spife_checker #(
    parameter int GAP_CYC = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [16:0] rdata_top,
    input logic        cs_n,
    input logic        sclk,
    input logic        mosi
);
    int   hi_run;
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= 0;
            armed  <= 1'b0;
        end else begin
            if (cs_n) hi_run <= (hi_run < GAP_CYC) ? hi_run + 1 : hi_run;
            else      hi_run <= 0;
            if (!cs_n) armed <= 1'b1;
        end
    end

    assert_sclk_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_mosi_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk) |-> $stable(mosi));

    assert_gap_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && armed) |-> (hi_run >= GAP_CYC));

    assert_cs_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    assert_sign_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rdata_top == {17{rdata_top[0]}}));
endmodule

bind spi_frame_engine spife_checker #(.GAP_CYC((CLK_HZ / 1_000_000) * GAP_US)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .rdata_top (rdata[31:15]),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .mosi      (mosi)
);

// File: tb/sim_spi_frame_engine.sv
module sim_spi_frame_engine;
    localparam int CLK_HZ  = 2_000_000;
    localparam int GAP_US  = 10;
    localparam int GAP_CYC = (CLK_HZ / 1_000_000) * GAP_US;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        busy, done, crc_err, status_err, sclk, cs_n, mosi;
    logic        miso = 1'b0;
    logic [31:0] rdata;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    spi_frame_engine #(.CLK_HZ(CLK_HZ), .GAP_US(GAP_US), .SCLK_HALF(2)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata), .crc_err(crc_err),
        .status_err(status_err), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // sensor model
    logic [31:0] rsp_word = '0;
    logic [31:0] sh = '0;
    logic [31:0] cap = '0;
    logic [31:0] last_cmd = '0;
    int edges = 0, cmd_edges = 0, rsp_edges = 0, frames = 0;

    always @(negedge cs_n) begin
        sh    = (frames % 2 == 1) ? rsp_word : 32'hA5A5_A5A5;
        miso  = sh[31];
        edges = 0;
        cap   = '0;
    end
    always @(posedge sclk) if (!cs_n) begin
        cap   = {cap[30:0], mosi};
        edges = edges + 1;
    end
    always @(negedge sclk) if (!cs_n) begin
        sh   = {sh[30:0], 1'b0};
        miso = sh[31];
    end
    always @(posedge cs_n) begin
        if (frames % 2 == 0) begin
            last_cmd  = cap;
            cmd_edges = edges;
        end else begin
            rsp_edges = edges;
        end
        frames = frames + 1;
    end

    int hi_run = 0, last_gap = 0;
    always @(posedge clk) begin
        if (cs_n) hi_run <= hi_run + 1;
        else begin
            if (hi_run != 0) last_gap <= hi_run;
            hi_run <= 0;
        end
    end

    function automatic logic [7:0] ref_crc(input logic [23:0] d);
        logic [7:0] c;
        c = 8'hFF;
        for (int i = 23; i >= 0; i--) begin
            c = (c[7] ^ d[i]) ? ({c[6:0], 1'b0} ^ 8'h1D) : {c[6:0], 1'b0};
        end
        return ~c;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [4:0] a, input logic [15:0] wd,
                        input logic [15:0] rd, input logic [1:0] stt,
                        input logic corrupt, input logic poke);
        logic [31:0] exp_cmd;
        logic [7:0]  rb0, rc;
        int f0, n;
        exp_cmd[31:8] = {w, a, 2'b00, (w ? wd : 16'h0000)};
        exp_cmd[7:0]  = ref_crc(exp_cmd[31:8]);
        rb0 = {~w, a, stt};
        rc  = ref_crc({rb0, rd});
        if (corrupt) rc = rc ^ 8'h10;
        rsp_word = {rb0, rd, rc};
        f0 = frames;
        @(negedge clk);
        start = 1'b1; wr_en = w; addr = a; wdata = wd;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9 busy after start", {31'b0, busy}, 32'd1);
        n = 0;
        while (done !== 1'b1 && n < 5000) begin
            if (poke && n == 40) begin
                start = 1'b1; addr = ~a; wr_en = ~w; wdata = ~wd;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(n < 5000, "R9 done timeout", n, 5000);
        chk(last_cmd[31:24] == exp_cmd[31:24], "R1 command byte", last_cmd[31:24], exp_cmd[31:24]);
        chk(last_cmd[23:8] == exp_cmd[23:8], "R2 data bytes", last_cmd[23:8], exp_cmd[23:8]);
        chk(last_cmd[7:0] == exp_cmd[7:0], "R3 crc byte", last_cmd[7:0], exp_cmd[7:0]);
        chk(cmd_edges == 32 && rsp_edges == 32, "R4 edges per frame", cmd_edges * 256 + rsp_edges, 32 * 256 + 32);
        chk(frames == f0 + 2, "R4 R9 two frames per access", frames - f0, 2);
        chk(last_gap >= GAP_CYC, "R5 inter-frame gap", last_gap, GAP_CYC);
        chk(hi_run >= GAP_CYC, "R5 trailing gap", hi_run, GAP_CYC);
        chk(rdata == {{16{rd[15]}}, rd}, "R6 rdata", rdata, {{16{rd[15]}}, rd});
        chk(crc_err == corrupt, "R7 crc_err", {31'b0, crc_err}, {31'b0, corrupt});
        chk(status_err == (stt == 2'b11), "R8 status_err", {31'b0, status_err}, {31'b0, (stt == 2'b11)});
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9 done one cycle", {30'b0, done, busy}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        frames = 0;
        @(negedge clk);
        chk(cs_n === 1'b1, "R10 cs_n reset", {31'b0, cs_n}, 32'd1);
        chk(sclk === 1'b0, "R10 sclk reset", {31'b0, sclk}, 32'd0);
        chk(busy === 1'b0 && done === 1'b0, "R10 busy/done reset", {30'b0, busy, done}, 32'd0);
        chk(crc_err === 1'b0 && status_err === 1'b0, "R10 flags reset", {30'b0, crc_err, status_err}, 32'd0);

        for (int a = 0; a < 32; a++) begin
            for (int w = 0; w < 2; w++) begin
                xfer(w[0], a[4:0], 16'(a * 16'h0843) ^ (w[0] ? 16'hF00F : 16'h1234),
                     16'(a * 16'h0A13 + w * 16'h8000), 2'(a + w), (a % 5 == 0), 1'b0);
            end
        end
        xfer(1'b0, 5'd3,  16'h0000, 16'h7FFF, 2'd0, 1'b0, 1'b0);
        xfer(1'b0, 5'd4,  16'h0000, 16'h8000, 2'd3, 1'b0, 1'b0);
        xfer(1'b1, 5'd31, 16'hFFFF, 16'hFFFF, 2'd1, 1'b1, 1'b0);
        xfer(1'b1, 5'd0,  16'h0000, 16'h0000, 2'd2, 1'b0, 1'b0);
        // start raised mid-access must not change or add frames (R9)
        xfer(1'b1, 5'd10, 16'hBEEF, 16'h1357, 2'd0, 1'b0, 1'b1);
        begin
            int f1;
            f1 = frames;
            repeat (200) @(negedge clk);
            chk(frames == f1 && cs_n === 1'b1, "R9 no extra frame", frames - f1, 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule